// File: doc/BRIEF.md
# Two-Phase Watchdog Timer with Pretimeout Interrupt

This block is a watchdog timer with two stages that run one after the other. A bus-clock divider produces scaled ticks. The divider length is a power of two set by a parameter, and a 2-bit logarithmic scale field stretches it further. Once enabled, the first stage counts a programmable number of ticks and then raises an interrupt. This gives software a last chance to react. The expiry of the first stage also locks the timer on. The second stage then counts its own number of ticks, and at its end the block pulses one of three reset outputs for one clock. Which output is pulsed depends on a mode field. After the pulse, all state returns to its power-on values.

Software reaches the block through a plain 32-bit register port with three word addresses:
- Address 0x0 is a kick port. Writing 1 to bit 31 restarts the countdown, and reads return zero.
- Address 0x4 holds the two expiry flags, which are cleared by writing 1.
- Address 0x8 is the control word.

The reset generator that consumes the pulses and any bus bridge in front of the port lie outside this block.

Top module: `dual_phase_wdt`

## Requirements
- R1: After reset, the control word at 0x8 reads 0x00000001 (timer disabled, mode 1), the flag word at 0x4 and the kick word at 0x0 read zero, and the interrupt and all three reset outputs are low.
- R2: One tick lasts 2^(BASE_EXP+scale) clock cycles. Scale is control bits 30:29. After enable bit 31 is set, stage one expires after (S1+1) ticks, where S1 is control bits 26:22. Its expiry sets flag bit 31 at 0x4 and raises the interrupt.
- R3: Stage two starts when stage one expires and lasts (S2+1) ticks, where S2 is control bits 19:15. Its expiry sets flag bit 30 and pulses the selected reset output high for exactly one clock.
- R4: The mode field (control bits 1:0) selects the reset output. Mode 0 selects the whole-chip output, mode 1 the CPU output and mode 2 the software output. Mode 3 acts as mode 0. At most one reset output is ever high.
- R5: In the clock after a reset pulse, the control word, both flags and the counters return to their power-on values.
- R6: Writing 1 to a flag bit at 0x4 clears that flag, and writing 0 leaves it unchanged. The interrupt output is high whenever either flag is set.
- R7: A write to 0x0 with bit 31 set restarts stage one from zero ticks and a fresh divider, and cancels stage two. A write to 0x0 with bit 31 clear has no effect. A kick in the same cycle as a stage expiry loses to the expiry.
- R8: While enable is clear and stage one has not expired, the counters hold at zero. Setting enable later starts stage one from zero.
- R9: After stage one has expired, a control write cannot clear the enable bit: it reads back as 1, and the countdown continues to the reset pulse.
- R10: The control fields read back at the bit positions given in R2 to R4, and all other control bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 4 | Byte address of the register word (0x0, 0x4, 0x8) |
| regWData | input | 32 | Register write data |
| regRData | output | 32 | Read data for regAddr, combinational |
| irqOut | output | 1 | Pretimeout interrupt, OR of both flags |
| rstChipOut | output | 1 | Whole-chip reset pulse |
| rstCpuOut | output | 1 | CPU-only reset pulse |
| rstSoftOut | output | 1 | Software reset pulse |

## Verification
The assertions assume a write strobe that lasts one clock and addresses that are stable while the strobe is high. They also assume that the power-on reset is released away from the clock edge. The bench drives every write at the falling edge and drops the strobe right after the following rising edge, so each register access is a single clean cycle. The bench measures every expiry as a count of rising edges from the write that started or kicked the timer. It uses a short base exponent so that all scale settings, including the eight-fold one, fit within a few hundred cycles.

// File: rtl/dual_phase_wdt_pkg.sv
package dual_phase_wdt_pkg;

  localparam int PH_W    = 5;
  localparam int SCALE_W = 2;
  localparam int MODE_W  = 2;

  localparam logic [3:0] ADDR_KICK  = 4'h0;
  localparam logic [3:0] ADDR_FLAGS = 4'h4;
  localparam logic [3:0] ADDR_CTRL  = 4'h8;

  localparam int BIT_KICK   = 31;
  localparam int BIT_FLAG1  = 31;
  localparam int BIT_FLAG2  = 30;
  localparam int BIT_EN     = 31;
  localparam int LSB_SCALE  = 29;
  localparam int LSB_STAGE1 = 22;
  localparam int LSB_STAGE2 = 15;

  localparam logic [MODE_W-1:0] MODE_POWER_ON = 2'd1;

  // one-hot index of each reset output
  localparam int RST_CHIP = 0;
  localparam int RST_CPU  = 1;
  localparam int RST_SOFT = 2;

  typedef struct packed {
    logic               run;
    logic               restart;
    logic [SCALE_W-1:0] scale;
    logic [PH_W-1:0]    limit;
  } cnt_cmd_t;

  function automatic logic [2:0] modeOneHot(input logic [MODE_W-1:0] mode);
    logic [2:0] hot;
    hot = '0;
    case (mode)
      2'd1:    hot[RST_CPU]  = 1'b1;
      2'd2:    hot[RST_SOFT] = 1'b1;
      default: hot[RST_CHIP] = 1'b1;
    endcase
    return hot;
  endfunction

endpackage

// File: rtl/dual_phase_wdt_dp.sv
module dual_phase_wdt_dp
  import dual_phase_wdt_pkg::*;
#(
  parameter int BASE_EXP = 25
) (
  input  logic     clk,
  input  logic     rstN,
  input  cnt_cmd_t cntCmd,
  output logic     phaseDone
);

  localparam int DIV_W = BASE_EXP + (1 << SCALE_W) - 1;

  logic [DIV_W-1:0] divCnt;
  logic [PH_W-1:0]  tickCnt;
  logic [DIV_W-1:0] lastVal;
  logic             tickEnd;

  // last divider value of one scaled tick; >= tolerates a shrinking scale
  assign lastVal   = (DIV_W'(1) << (BASE_EXP + 32'(cntCmd.scale))) - DIV_W'(1);
  assign tickEnd   = cntCmd.run && (divCnt >= lastVal);
  assign phaseDone = tickEnd && (tickCnt >= cntCmd.limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      tickCnt <= '0;
    end else if (!cntCmd.run || cntCmd.restart) begin
      divCnt  <= '0;
      tickCnt <= '0;
    end else if (tickEnd) begin
      divCnt  <= '0;
      tickCnt <= phaseDone ? '0 : tickCnt + PH_W'(1);
    end else begin
      divCnt  <= divCnt + DIV_W'(1);
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !cntCmd.run |=> (divCnt == '0 && tickCnt == '0)); // R8

  AST_STAGE_REARM: assert property (@(posedge clk) disable iff (!rstN)
    phaseDone |=> (tickCnt == '0)); // R2

endmodule

// File: rtl/dual_phase_wdt_ctrl.sv
module dual_phase_wdt_ctrl
  import dual_phase_wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWData,
  output logic [31:0] regRData,
  input  logic        phaseDone,
  output cnt_cmd_t    cntCmd,
  output logic        irqOut,
  output logic [2:0]  rstPulse
);

  logic               enReg;
  logic [SCALE_W-1:0] scaleReg;
  logic [PH_W-1:0]    stage1Reg;
  logic [PH_W-1:0]    stage2Reg;
  logic [MODE_W-1:0]  modeReg;
  logic               flag1;
  logic               flag2;
  logic               stage2Active;

  logic wrKick, wrFlags, wrCtrl;
  logic stage1Done, stage2Done, pulseOn, restart;
  logic unusedWData;

  assign wrKick     = regWrEn && (regAddr == ADDR_KICK) && regWData[BIT_KICK];
  assign wrFlags    = regWrEn && (regAddr == ADDR_FLAGS);
  assign wrCtrl     = regWrEn && (regAddr == ADDR_CTRL);
  assign stage1Done = phaseDone && !stage2Active;
  assign stage2Done = phaseDone && stage2Active;
  assign pulseOn    = |rstPulse;
  assign restart    = wrKick && !phaseDone;
  assign unusedWData = ^{regWData[28:27], regWData[21:20], regWData[14:2]};

  assign cntCmd.run     = (enReg || stage2Active) && !pulseOn;
  assign cntCmd.restart = restart;
  assign cntCmd.scale   = scaleReg;
  assign cntCmd.limit   = stage2Active ? stage2Reg : stage1Reg;

  assign irqOut = flag1 || flag2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg        <= 1'b0;
      scaleReg     <= '0;
      stage1Reg    <= '0;
      stage2Reg    <= '0;
      modeReg      <= MODE_POWER_ON;
      flag1        <= 1'b0;
      flag2        <= 1'b0;
      stage2Active <= 1'b0;
      rstPulse     <= '0;
    end else if (pulseOn) begin
      enReg        <= 1'b0;
      scaleReg     <= '0;
      stage1Reg    <= '0;
      stage2Reg    <= '0;
      modeReg      <= MODE_POWER_ON;
      flag1        <= 1'b0;
      flag2        <= 1'b0;
      stage2Active <= 1'b0;
      rstPulse     <= '0;
    end else begin
      if (wrCtrl) begin
        // enable sticks once stage one has expired
        enReg     <= regWData[BIT_EN] || stage2Active || stage1Done;
        scaleReg  <= regWData[LSB_SCALE +: SCALE_W];
        stage1Reg <= regWData[LSB_STAGE1 +: PH_W];
        stage2Reg <= regWData[LSB_STAGE2 +: PH_W];
        modeReg   <= regWData[MODE_W-1:0];
      end
      flag1 <= (flag1 && !(wrFlags && regWData[BIT_FLAG1])) || stage1Done;
      flag2 <= (flag2 && !(wrFlags && regWData[BIT_FLAG2])) || stage2Done;
      if (stage1Done)
        stage2Active <= 1'b1;
      else if (stage2Done || restart)
        stage2Active <= 1'b0;
      rstPulse <= stage2Done ? modeOneHot(modeReg) : '0;
    end
  end

  always_comb begin
    regRData = '0;
    if (regAddr == ADDR_FLAGS) begin
      regRData[BIT_FLAG1] = flag1;
      regRData[BIT_FLAG2] = flag2;
    end else if (regAddr == ADDR_CTRL) begin
      regRData[BIT_EN]                     = enReg;
      regRData[LSB_SCALE +: SCALE_W]       = scaleReg;
      regRData[LSB_STAGE1 +: PH_W]         = stage1Reg;
      regRData[LSB_STAGE2 +: PH_W]         = stage2Reg;
      regRData[MODE_W-1:0]                 = modeReg;
    end
  end

  AST_ONE_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rstPulse)); // R4

  AST_PULSE_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN)
    pulseOn |=> !pulseOn); // R3

  AST_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    pulseOn |-> flag2); // R3

  AST_WIPE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pulseOn |=> (!enReg && !flag1 && !flag2 && !stage2Active
                 && modeReg == MODE_POWER_ON)); // R5

  AST_LOCKED_ON: assert property (@(posedge clk) disable iff (!rstN)
    stage2Active |-> enReg); // R9

endmodule

// File: rtl/dual_phase_wdt.sv
module dual_phase_wdt
  import dual_phase_wdt_pkg::*;
#(
  parameter int BASE_EXP = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWData,
  output logic [31:0] regRData,
  output logic        irqOut,
  output logic        rstChipOut,
  output logic        rstCpuOut,
  output logic        rstSoftOut
);

  cnt_cmd_t   cntCmd;
  logic       phaseDone;
  logic [2:0] rstPulse;

  dual_phase_wdt_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWData  (regWData),
    .regRData  (regRData),
    .phaseDone (phaseDone),
    .cntCmd    (cntCmd),
    .irqOut    (irqOut),
    .rstPulse  (rstPulse)
  );

  dual_phase_wdt_dp #(.BASE_EXP(BASE_EXP)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .cntCmd    (cntCmd),
    .phaseDone (phaseDone)
  );

  assign rstChipOut = rstPulse[RST_CHIP];
  assign rstCpuOut  = rstPulse[RST_CPU];
  assign rstSoftOut = rstPulse[RST_SOFT];

endmodule

// File: tb/dual_phase_wdt_test.sv
`timescale 1ns/1ps
module dual_phase_wdt_test;

  localparam int BASE_EXP = 2;
  localparam int BASE_TICK = 1 << BASE_EXP;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = 4'h0;
  logic [31:0] regWData = '0;
  logic [31:0] regRData;
  logic        irqOut, rstChipOut, rstCpuOut, rstSoftOut;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  dual_phase_wdt #(.BASE_EXP(BASE_EXP)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .irqOut(irqOut),
    .rstChipOut(rstChipOut), .rstCpuOut(rstCpuOut), .rstSoftOut(rstSoftOut)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCtrl(input bit en, input int scale, input int s1,
                                         input int s2, input int mode);
    return {en, 2'(scale), 2'b00, 5'(s1), 2'b00, 5'(s2), 13'd0, 2'(mode)};
  endfunction

  // write lands on the next rising edge; returns with cyc counting that edge
  task automatic busWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWData = d;
    @(posedge clk);
    #1;
    regWrEn = 1'b0; regWData = '0;
  endtask

  task automatic busRd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRData;
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // wantPulse=0 waits for irq, 1 for any reset output; rel is edges since ref0
  task automatic waitEvt(input bit wantPulse, input int ref0, output int rel);
    rel = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (wantPulse ? (rstChipOut | rstCpuOut | rstSoftOut) : irqOut) begin
        rel = cyc - ref0;
        break;
      end
    end
  endtask

  function automatic logic [31:0] rstVec();
    return {29'd0, rstSoftOut, rstCpuOut, rstChipOut};
  endfunction

  function automatic logic [31:0] expVec(input int mode);
    case (mode)
      1: return 32'd2;
      2: return 32'd4;
      default: return 32'd1;
    endcase
  endfunction

  task automatic checkWiped(input string tag);
    logic [31:0] d;
    @(negedge clk);
    chk({tag, " R3 pulse one clock"}, rstVec(), 32'd0);
    busRd(ADDR_C, d);
    chk({tag, " R5 ctrl power-on"}, d, 32'h0000_0001);
    busRd(ADDR_F, d);
    chk({tag, " R5 flags cleared"}, d, 32'h0);
    chk({tag, " R5 irq low"}, 32'(irqOut), 32'd0);
  endtask

  localparam logic [3:0] ADDR_K = 4'h0;
  localparam logic [3:0] ADDR_F = 4'h4;
  localparam logic [3:0] ADDR_C = 4'h8;

  task automatic tReset();
    logic [31:0] d;
    busRd(ADDR_C, d); chk("R1 ctrl reset value", d, 32'h0000_0001);
    busRd(ADDR_F, d); chk("R1 flags reset value", d, 32'h0);
    busRd(ADDR_K, d); chk("R1 kick reads zero", d, 32'h0);
    chk("R1 outputs low", {27'd0, irqOut, rstVec()[2:0], 1'b0}, 32'd0);
  endtask

  task automatic tFullRun(input int scale, input int s1, input int s2, input int mode);
    logic [31:0] d, w;
    int start, rel, s;
    s = 1 << scale;
    w = mkCtrl(1'b1, scale, s1, s2, mode);
    busWr(ADDR_C, w);
    start = cyc;
    busRd(ADDR_C, d); chk("R10 ctrl readback", d, w);
    waitEvt(1'b0, start, rel);
    chk("R2 stage one length", 32'(rel), 32'(BASE_TICK * s * (s1 + 1)));
    busRd(ADDR_F, d); chk("R2 stage one flag", d, 32'h8000_0000);
    waitEvt(1'b1, start, rel);
    chk("R3 stage two length", 32'(rel), 32'(BASE_TICK * s * (s1 + s2 + 2)));
    chk("R4 selected reset output", rstVec(), expVec(mode));
    busRd(ADDR_F, d); chk("R3 both flags at pulse", d, 32'hC000_0000);
    checkWiped("full run");
  endtask

  task automatic tClearAndLock();
    logic [31:0] d;
    int start, rel;
    busWr(ADDR_C, mkCtrl(1'b1, 0, 0, 7, 2));
    start = cyc;
    waitEvt(1'b0, start, rel);
    chk("R2 irq at stage one end", 32'(rel), 32'(BASE_TICK));
    busWr(ADDR_F, 32'h0);
    busRd(ADDR_F, d); chk("R6 zero write keeps flag", d, 32'h8000_0000);
    chk("R6 irq still high", 32'(irqOut), 32'd1);
    busWr(ADDR_F, 32'h8000_0000);
    busRd(ADDR_F, d); chk("R6 flag cleared by one", d, 32'h0);
    chk("R6 irq low after clear", 32'(irqOut), 32'd0);
    busWr(ADDR_C, mkCtrl(1'b0, 0, 0, 7, 2));
    busRd(ADDR_C, d); chk("R9 enable locked on", d, mkCtrl(1'b1, 0, 0, 7, 2));
    waitEvt(1'b1, start, rel);
    chk("R9 countdown continues", 32'(rel), 32'(BASE_TICK * 9));
    chk("R4 software reset", rstVec(), 32'd4);
    chk("R6 irq from stage-two flag", 32'(irqOut), 32'd1);
    checkWiped("lock");
  endtask

  task automatic tKickStage1();
    int start, k, rel;
    busWr(ADDR_C, mkCtrl(1'b1, 0, 3, 0, 1));
    start = cyc;
    busWr(ADDR_K, 32'h7FFF_FFFF);
    waitEdges(3);
    busWr(ADDR_K, 32'h8000_0000);
    k = cyc;
    chk("R7 kick landed mid stage", 32'(k - start > 4), 32'd1);
    waitEvt(1'b0, k, rel);
    chk("R7 stage one restarts on kick", 32'(rel), 32'(BASE_TICK * 4));
    waitEvt(1'b1, k, rel);
    chk("R7 pulse after kicked run", 32'(rel), 32'(BASE_TICK * 5));
    checkWiped("kick1");
  endtask

  task automatic tKickStage2();
    int start, k, rel;
    busWr(ADDR_C, mkCtrl(1'b1, 0, 0, 3, 1));
    start = cyc;
    waitEvt(1'b0, start, rel);
    chk("R2 stage one before kick", 32'(rel), 32'(BASE_TICK));
    busWr(ADDR_F, 32'h8000_0000);
    waitEdges(2);
    busWr(ADDR_K, 32'h8000_0000);
    k = cyc;
    waitEvt(1'b0, k, rel);
    chk("R7 kick cancels stage two", 32'(rel), 32'(BASE_TICK));
    busWr(ADDR_F, 32'h8000_0000);
    waitEvt(1'b1, k, rel);
    chk("R7 pulse delayed by kick", 32'(rel), 32'(BASE_TICK * 5));
    chk("R4 cpu reset", rstVec(), 32'd2);
    checkWiped("kick2");
  endtask

  task automatic tDisable();
    logic [31:0] d;
    int r, rel;
    busWr(ADDR_C, mkCtrl(1'b1, 0, 3, 0, 0));
    waitEdges(6);
    busWr(ADDR_C, mkCtrl(1'b0, 0, 3, 0, 0));
    waitEdges(20);
    chk("R8 no expiry while disabled", 32'(irqOut), 32'd0);
    busRd(ADDR_F, d); chk("R8 flags stay clear", d, 32'h0);
    busWr(ADDR_C, mkCtrl(1'b1, 0, 3, 0, 0));
    r = cyc;
    waitEvt(1'b0, r, rel);
    chk("R8 re-enable starts from zero", 32'(rel), 32'(BASE_TICK * 4));
    waitEvt(1'b1, r, rel);
    chk("R8 pulse after re-enable", 32'(rel), 32'(BASE_TICK * 5));
    chk("R4 chip reset", rstVec(), 32'd1);
    checkWiped("disable");
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #21 rstN = 1'b1;
    waitEdges(2);
    tReset();
    tFullRun(0, 2, 1, 1);
    tFullRun(2, 0, 0, 0);
    tFullRun(0, 0, 0, 2);
    tFullRun(0, 0, 0, 3);
    tFullRun(1, 1, 2, 1);
    tFullRun(3, 0, 0, 2);
    tClearAndLock();
    tKickStage1();
    tKickStage2();
    tDisable();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule